// File: doc/BRIEF.md
# Charge-Time Stage-Count Tracking Controller

This controller decides how many stages of a reconfigurable multi-stage RF-to-DC rectifier should be in the signal path. Stage 1 is always in the path. Every other stage has a pair of switches: one puts the stage in the path and the other bypasses it. The controller scores a stage count by timing how long the converter output needs to rise from a low reference to a high reference. Two comparators outside the block supply flags that say whether the output is above each reference.

A search begins with only stage 1 active. Before each timing the controller asks an external discharge path to pull the output below the low reference. It then times the rise. After that it adds one stage and times the rise again. The search goes on for as long as each new timing is strictly shorter than the best timing so far. When the rise gets slower or stays the same, the controller drops back by one stage and locks the switches there. If every stage is in use and the rise is still getting faster, it locks at the full stage count.

The timer saturates at its largest value. A rise that never completes therefore scores as the slowest possible result, which also acts as a timeout. A new start request after the lock begins a fresh search.

Top module: `stage_mppt_ctrl`

## Requirements
- R1: After reset the stage count output is 1, every enable bit is 0, every bypass bit is 1, and both the lock flag and the discharge request are 0.
- R2: For every switchable stage, the bypass bit is always the inverse of the enable bit.
- R3: The enable vector is a thermometer code. Bit i (stage i+2) is 1 exactly when the stage count is at least i+2, and the stage count stays between 1 and NUM_STAGES.
- R4: The first timing of every search is taken with a stage count of 1 (all enable bits 0).
- R5: Before each timing the discharge request is held high for as long as the synchronized low-reference flag stays high. It drops once that flag reads low, and the timer starts only on a later rising edge of the low-reference flag.
- R6: When a timing is strictly shorter than the best timing so far, that timing becomes the new best. The stage count then goes up by one and another timing follows.
- R7: When a timing is longer than or equal to the best timing so far, the stage count goes down by one, the lock flag rises, and the count is held.
- R8: When the stage count is NUM_STAGES and its timing is still strictly shorter than the best, the controller locks at NUM_STAGES.
- R9: The timer saturates at 2^CNT_W-1. A saturated timer ends the timing and scores as the slowest possible result, so a high-reference flag that never rises cannot hang the search.
- R10: A start request while locked clears the lock flag, sets the stage count to 1 and begins a new search.
- R11: While locked and with no start request, the stage count and the lock flag stay constant. Whenever the count changes, it moves by one or returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (sampled while idle or locked) |
| above_lo_i | input | 1 | Comparator flag: output above the low reference (asynchronous) |
| above_hi_i | input | 1 | Comparator flag: output above the high reference (asynchronous) |
| sw_en_o | output | NUM_STAGES-1 | Stage enable switches; bit i controls stage i+2 |
| sw_byp_o | output | NUM_STAGES-1 | Stage bypass switches, the inverse of sw_en_o |
| discharge_o | output | 1 | Request to discharge the output below the low reference |
| locked_o | output | 1 | The search has finished and the stage count is held |
| stage_cnt_o | output | $clog2(NUM_STAGES+1) | Active stage count, from 1 to NUM_STAGES |

## Verification
The assertions check several properties on every cycle:
- the switch pairs are complementary and the enable vector is a thermometer code that matches the stage count;
- the count stays in range and moves only one step at a time or back to 1;
- nothing moves while locked;
- no discharge is requested during the lock.

Some behaviour only the bench's scenarios can show, because it depends on how the timings compare across a search. This covers:
- where the search stops when the rise times reach their lowest point in the middle of the range;
- a lock at the full count when the rise keeps getting faster;
- dropping back when the timing worsens or ties;
- a saturated timing;
- the discharge request being held while the low-reference flag stays high.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_EVAL,
    ST_LOCK
  } mppt_state_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign q_o    = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/charge_timer.sv
module charge_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sat_o
);
  logic [CNT_W-1:0] cnt_q;

  assign sat_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && !sat_o)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/stage_switch_dec.sv
module stage_switch_dec #(
  parameter int unsigned NUM_STAGES = 5,
  localparam int unsigned SC_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned NSW  = NUM_STAGES - 1
) (
  input  logic [SC_W-1:0] cnt_i,
  output logic [NSW-1:0]  en_o,
  output logic [NSW-1:0]  byp_o
);
  for (genvar i = 0; i < NSW; i++) begin : g_sw
    assign en_o[i]  = (cnt_i > SC_W'(i + 1));
    assign byp_o[i] = ~en_o[i];
  end
endmodule

// File: rtl/stage_mppt_ctrl.sv
module stage_mppt_ctrl #(
  parameter int unsigned NUM_STAGES  = 5,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SC_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned NSW  = NUM_STAGES - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            above_lo_i,
  input  logic            above_hi_i,
  output logic [NSW-1:0]  sw_en_o,
  output logic [NSW-1:0]  sw_byp_o,
  output logic            discharge_o,
  output logic            locked_o,
  output logic [SC_W-1:0] stage_cnt_o
);
  import mppt_pkg::*;

  localparam logic [SC_W-1:0] MAX_SC = SC_W'(NUM_STAGES);
  localparam logic [SC_W-1:0] ONE_SC = SC_W'(1);

  mppt_state_e      state_q, state_d;
  logic [SC_W-1:0]  stage_q, stage_d;
  logic [CNT_W-1:0] best_q, best_d;
  logic             first_q, first_d;
  logic             locked_q, locked_d;

  logic [1:0] flag_raw, flag_lvl, flag_rise;
  assign flag_raw = {above_hi_i, above_lo_i};

  for (genvar f = 0; f < 2; f++) begin : g_sync
    flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (flag_raw[f]),
      .q_o   (flag_lvl[f]),
      .rise_o(flag_rise[f])
    );
  end

  logic             lo_lvl, lo_rise, hi_rise;
  assign lo_lvl  = flag_lvl[0];
  assign lo_rise = flag_rise[0];
  assign hi_rise = flag_rise[1];

  logic [CNT_W-1:0] meas;
  logic             sat;
  logic             tmr_clear, tmr_run;

  assign tmr_clear = (state_q == ST_WAIT_LO);
  assign tmr_run   = (state_q == ST_WAIT_HI) && !hi_rise;

  charge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(tmr_clear),
    .run_i  (tmr_run),
    .count_o(meas),
    .sat_o  (sat)
  );

  always_comb begin
    state_d  = state_q;
    stage_d  = stage_q;
    best_d   = best_q;
    first_d  = first_q;
    locked_d = locked_q;
    unique case (state_q)
      ST_IDLE, ST_LOCK: begin
        if (start_i) begin
          stage_d  = ONE_SC;
          first_d  = 1'b1;
          locked_d = 1'b0;
          state_d  = ST_DISCH;
        end
      end
      ST_DISCH:   if (!lo_lvl) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (lo_rise) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (hi_rise || sat) state_d = ST_EVAL;
      ST_EVAL: begin
        if (first_q || (meas < best_q)) begin
          best_d  = meas;
          first_d = 1'b0;
          if (stage_q < MAX_SC) begin
            stage_d = stage_q + ONE_SC;
            state_d = ST_DISCH;
          end else begin
            locked_d = 1'b1;
            state_d  = ST_LOCK;
          end
        end else begin
          stage_d  = stage_q - ONE_SC;
          locked_d = 1'b1;
          state_d  = ST_LOCK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      stage_q  <= ONE_SC;
      best_q   <= '1;
      first_q  <= 1'b1;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      stage_q  <= stage_d;
      best_q   <= best_d;
      first_q  <= first_d;
      locked_q <= locked_d;
    end
  end

  stage_switch_dec #(.NUM_STAGES(NUM_STAGES)) u_dec (
    .cnt_i(stage_q),
    .en_o (sw_en_o),
    .byp_o(sw_byp_o)
  );

  assign discharge_o = (state_q == ST_DISCH);
  assign locked_o    = locked_q;
  assign stage_cnt_o = stage_q;
endmodule

// File: rtl/stage_mppt_ctrl_chk.sv
module stage_mppt_ctrl_chk #(
  parameter int unsigned NUM_STAGES = 5,
  localparam int unsigned SC_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned NSW  = NUM_STAGES - 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [NSW-1:0]  sw_en_o,
  input logic [NSW-1:0]  sw_byp_o,
  input logic            discharge_o,
  input logic            locked_o,
  input logic [SC_W-1:0] stage_cnt_o
);
  localparam logic [SC_W-1:0] MAX_SC = SC_W'(NUM_STAGES);
  localparam logic [SC_W-1:0] ONE_SC = SC_W'(1);

  p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_byp_o == ~sw_en_o);

  p_thermo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_en_o & (sw_en_o + NSW'(1))) == '0) &&
    ($countones(sw_en_o) == int'(stage_cnt_o) - 1));

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_cnt_o >= ONE_SC) && (stage_cnt_o <= MAX_SC));

  p_lock_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !start_i) |=> (locked_o && $stable(stage_cnt_o)));

  p_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_cnt_o == $past(stage_cnt_o)) ||
    (stage_cnt_o == $past(stage_cnt_o) + ONE_SC) ||
    (stage_cnt_o + ONE_SC == $past(stage_cnt_o)) ||
    (stage_cnt_o == ONE_SC));

  p_no_disch_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discharge_o |-> !locked_o);
endmodule

bind stage_mppt_ctrl stage_mppt_ctrl_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .sw_en_o    (sw_en_o),
  .sw_byp_o   (sw_byp_o),
  .discharge_o(discharge_o),
  .locked_o   (locked_o),
  .stage_cnt_o(stage_cnt_o)
);

// File: tb/stage_mppt_ctrl_tb.sv
`timescale 1ns/1ps
module stage_mppt_ctrl_tb;
  localparam int NS  = 5;
  localparam int SCW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, lo = 1'b0, hi = 1'b0;
  logic [NS-2:0]  en, byp;
  logic           disch, locked;
  logic [SCW-1:0] scnt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  stage_mppt_ctrl #(.NUM_STAGES(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .above_lo_i(lo), .above_hi_i(hi),
    .sw_en_o(en), .sw_byp_o(byp), .discharge_o(disch),
    .locked_o(locked), .stage_cnt_o(scnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int therm(input int k);
    return (1 << (k - 1)) - 1;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(locked == 1'b0, "R10 lock cleared", int'(locked), 0);
    chk(int'(scnt) == 1, "R10 restart count", int'(scnt), 1);
  endtask

  // one timing: stage count k expected, rise delay d (-1: never rises)
  task automatic serve(input int k, input int d);
    int guard = 0;
    while (!disch && guard < 1000) begin @(negedge clk); guard++; end
    chk(disch == 1'b1, "R5 discharge asserted", int'(disch), 1);
    chk(int'(scnt) == k, "R6 stage count at timing", int'(scnt), k);
    chk(int'(en) == therm(k), "R3 enable code", int'(en), therm(k));
    chk(byp == ~en, "R2 complement", int'(byp), int'(~en));
    if (k == 1) chk(en == '0, "R4 first timing one stage", int'(en), 0);
    repeat (5) @(negedge clk);
    chk(disch == 1'b1, "R5 discharge held while low flag high", int'(disch), 1);
    lo = 1'b0; hi = 1'b0;
    guard = 0;
    while (disch && guard < 100) begin @(negedge clk); guard++; end
    chk(disch == 1'b0, "R5 discharge released", int'(disch), 0);
    repeat (3) @(negedge clk);
    lo = 1'b1;
    if (d >= 0) begin
      repeat (d) @(negedge clk);
      hi = 1'b1;
    end
  endtask

  task automatic wait_lock(input int exp, input string req);
    int guard = 0;
    while (!locked && guard < 80000) begin @(negedge clk); guard++; end
    chk(locked == 1'b1, req, int'(locked), 1);
    chk(int'(scnt) == exp, req, int'(scnt), exp);
    chk(int'(en) == therm(exp), req, int'(en), therm(exp));
    repeat (10) @(negedge clk);
    chk(int'(scnt) == exp && locked, "R11 lock held", int'(scnt), exp);
    chk(disch == 1'b0, "R11 no discharge while locked", int'(disch), 0);
  endtask

  task automatic t_reset();
    chk(int'(scnt) == 1, "R1 reset count", int'(scnt), 1);
    chk(en == '0, "R1 reset enables", int'(en), 0);
    chk(byp == '1, "R1 reset bypass", int'(byp), 15);
    chk(!locked && !disch, "R1 reset flags", int'({locked, disch}), 0);
    lo = 1'b1; hi = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_peak();
    pulse_start();
    serve(1, 100); serve(2, 80); serve(3, 60); serve(4, 90);
    wait_lock(3, "R7 revert after slower");
  endtask

  task automatic t_all();
    pulse_start();
    serve(1, 100); serve(2, 90); serve(3, 80); serve(4, 70); serve(5, 60);
    wait_lock(5, "R8 lock at max");
  endtask

  task automatic t_worse();
    pulse_start();
    serve(1, 50); serve(2, 70);
    wait_lock(1, "R7 revert to one");
  endtask

  task automatic t_equal();
    pulse_start();
    serve(1, 60); serve(2, 60);
    wait_lock(1, "R7 tie reverts");
  endtask

  task automatic t_timeout();
    pulse_start();
    serve(1, 40); serve(2, -1);
    wait_lock(1, "R9 saturated is slowest");
    hi = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_peak();
    t_all();
    t_worse();
    t_equal();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule